// File: doc/BRIEF.md
# Two-Stream Pixel Compositing Engine

The engine combines two pixel streams that advance in lock-step: one read from the local frame buffer and one partial image from the node upstream. Each stream delivers 16-bit words, and one shared enable qualifies both. The engine collects four words per stream into a full pixel with red, green, blue, alpha and depth fields. It merges the two pixels with a function that software selects. It then sends the result out again as four 16-bit words toward the network side.

There are three merge functions. Depth compare keeps the nearer pixel. Alpha blend lays the local pixel over the upstream one. Tile select keeps the local pixel only inside a screen rectangle, which the engine tracks with its own X/Y scan counters. A small host-writable register file holds the mode, the screen size and the rectangle bounds. The output side uses a valid/ready handshake. When downstream stalls, the engine withdraws input acceptance so that no word is lost.

Top module: `pix_merge`

## Requirements
- R1: After reset, out_valid_o is low, in_rdy_o is high, the mode is depth compare and both scan counters are zero.
- R2: A pixel is four words in order. Word 0 is {G,R}, word 1 is {A,B}, word 2 is depth[15:0] and word 3 is depth[31:16]. Each channel occupies bits [7:0] or [15:8] as listed. The merged pixel leaves in the same word order. Its word 0 is on out_data_o with out_valid_o high in the cycle after the edge that accepts the fourth input word.
- R3: In depth mode the whole local pixel is output when its depth is less than or equal to the upstream depth, so ties go to local. Otherwise the upstream pixel is output.
- R4: In blend mode each colour channel is round((a_l·c_l + (255−a_l)·c_u)/255). Here a_l is the local alpha, c_l is the local channel and c_u is the upstream channel.
- R5: In blend mode the output alpha is a_l + round(a_u·(255−a_l)/255), and the output depth is the smaller of the two depths.
- R6: In tile mode the local pixel is output when x_lo ≤ X ≤ x_hi and y_lo ≤ Y ≤ y_hi (bounds inclusive). Otherwise the upstream pixel is output.
- R7: Each completed pixel advances X. When X is at width−1 it wraps to 0 and Y advances. When Y is at height−1 it wraps to 0.
- R8: A one-cycle frame_start_i pulse returns X and Y to zero. The next pixel is treated as (0,0).
- R9: While out_valid_o is high and out_ready_i is low, out_data_o and out_valid_o hold. in_rdy_o drops rather than lose a pixel, and every accepted pixel is emitted exactly once.
- R10: Configuration is written with cfg_we_i at cfg_addr_i. Address 0 holds the mode in bits [1:0]: 0 is depth, 1 is blend, 2 is tile, and 3 behaves as depth. Address 1 holds width in [15:0] and height in [31:16]. Address 2 holds x_lo in [15:0] and x_hi in [31:16]. Address 3 holds y_lo in [15:0] and y_hi in [31:16].
- R11: Words presented while in_en_i is low are ignored. They neither enter a pixel nor produce output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_start_i | input | 1 | Clears the scan counters |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 2 | Configuration word select |
| cfg_wdata_i | input | 32 | Configuration write data |
| in_en_i | input | 1 | Shared enable for both input words |
| loc_word_i | input | 16 | Local frame-buffer word |
| ups_word_i | input | 16 | Upstream partial-image word |
| in_rdy_o | output | 1 | Input words are accepted this cycle when high with in_en_i |
| out_valid_o | output | 1 | Output word valid |
| out_data_o | output | 16 | Merged output word |
| out_ready_i | input | 1 | Downstream accepts the output word |

## Verification
The merge is decided at the edge that accepts the fourth word pair, and word 0 of the result is valid one cycle later. The remaining words follow on each cycle in which out_ready_i is high. in_rdy_o responds in the same cycle to out_ready_i. For this reason the bench drives inputs on the falling edge and reads in_rdy_o one nanosecond later, before it decides whether a word was taken. Output words are sampled just before the rising edge that transfers them, reassembled into pixels, and compared in order against a queue of pixels the bench computed from the requirements. A stall is checked on the cycle that follows it.

// File: rtl/pm_pkg.sv
package pm_pkg;
  localparam int WORD_W  = 16;
  localparam int CH_W    = 8;
  localparam int N_CH    = 3;
  localparam int Z_W     = 32;
  localparam int PIX_W   = (N_CH + 1) * CH_W + Z_W;
  localparam int N_WORDS = PIX_W / WORD_W;
  localparam int WIDX_W  = $clog2(N_WORDS);
  localparam int PROD_W  = 2 * CH_W;
  localparam logic [CH_W-1:0] CH_MAX = {CH_W{1'b1}};

  typedef struct packed {
    logic [Z_W-1:0]  z;
    logic [CH_W-1:0] a;
    logic [CH_W-1:0] b;
    logic [CH_W-1:0] g;
    logic [CH_W-1:0] r;
  } pix_t;

  typedef enum logic [1:0] {
    MODE_DEPTH = 2'd0,
    MODE_BLEND = 2'd1,
    MODE_TILE  = 2'd2,
    MODE_RSVD  = 2'd3
  } mode_e;

  // rounded division of a channel product by full scale
  function automatic logic [CH_W-1:0] div_fs(input logic [PROD_W-1:0] p);
    logic [PROD_W:0] t;
    logic [PROD_W:0] u;
    t = {1'b0, p} + (PROD_W+1)'(1 << (CH_W - 1));
    u = t + (t >> CH_W);
    return u[PROD_W-1:CH_W];
  endfunction
endpackage

// File: rtl/pm_deser.sv
module pm_deser
  import pm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [WIDX_W-1:0] idx_i,
  input  logic [WORD_W-1:0] word_i,
  output pix_t              pix_o
);
  logic [N_WORDS-2:0][WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (take_i) begin
      for (int k = 0; k < N_WORDS - 1; k++) begin
        if (idx_i == WIDX_W'(k)) hold_q[k] <= word_i;
      end
    end
  end

  // last word bypasses the holding slots
  assign pix_o = pix_t'({word_i, hold_q});
endmodule

// File: rtl/pm_scan.sv
module pm_scan #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  input  logic [CW-1:0] w_i,
  input  logic [CW-1:0] h_i,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  logic [CW-1:0] x_q, y_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_q <= '0;
      y_q <= '0;
    end else if (clr_i) begin
      x_q <= '0;
      y_q <= '0;
    end else if (step_i) begin
      if (x_q >= w_i - CW'(1)) begin
        x_q <= '0;
        y_q <= (y_q >= h_i - CW'(1)) ? '0 : y_q + CW'(1);
      end else begin
        x_q <= x_q + CW'(1);
      end
    end
  end

  assign x_o = x_q;
  assign y_o = y_q;
endmodule

// File: rtl/pm_blend.sv
module pm_blend
  import pm_pkg::*;
(
  input  pix_t src_i,
  input  pix_t dst_i,
  output pix_t pix_o
);
  logic [N_CH-1:0][CH_W-1:0] cs, cd, co;
  logic [CH_W-1:0]   inv_a;
  logic [PROD_W-1:0] pa;

  assign cs    = {src_i.b, src_i.g, src_i.r};
  assign cd    = {dst_i.b, dst_i.g, dst_i.r};
  assign inv_a = CH_MAX - src_i.a;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic [PROD_W-1:0] p;
    assign p = PROD_W'(src_i.a) * PROD_W'(cs[c]) + PROD_W'(inv_a) * PROD_W'(cd[c]);
    assign co[c] = div_fs(p);
  end

  assign pa = PROD_W'(dst_i.a) * PROD_W'(inv_a);

  always_comb begin
    pix_o.r = co[0];
    pix_o.g = co[1];
    pix_o.b = co[2];
    pix_o.a = src_i.a + div_fs(pa);
    pix_o.z = (src_i.z < dst_i.z) ? src_i.z : dst_i.z;
  end
endmodule

// File: rtl/pm_merge.sv
module pm_merge
  import pm_pkg::*;
#(
  parameter int CW = 16
) (
  input  mode_e         mode_i,
  input  pix_t          loc_i,
  input  pix_t          ups_i,
  input  logic [CW-1:0] x_i,
  input  logic [CW-1:0] y_i,
  input  logic [CW-1:0] x_lo_i,
  input  logic [CW-1:0] x_hi_i,
  input  logic [CW-1:0] y_lo_i,
  input  logic [CW-1:0] y_hi_i,
  output pix_t          pix_o
);
  pix_t blend;
  logic near_loc, in_zone;

  pm_blend u_blend (
    .src_i (loc_i),
    .dst_i (ups_i),
    .pix_o (blend)
  );

  assign near_loc = (loc_i.z <= ups_i.z);
  assign in_zone  = (x_i >= x_lo_i) && (x_i <= x_hi_i) &&
                    (y_i >= y_lo_i) && (y_i <= y_hi_i);

  always_comb begin
    unique case (mode_i)
      MODE_BLEND: pix_o = blend;
      MODE_TILE:  pix_o = in_zone ? loc_i : ups_i;
      default:    pix_o = near_loc ? loc_i : ups_i;
    endcase
  end
endmodule

// File: rtl/pm_ser.sv
module pm_ser
  import pm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  pix_t              pix_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [WORD_W-1:0] word_o,
  output logic              free_o
);
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(N_WORDS - 1);

  logic [N_WORDS-1:0][WORD_W-1:0] buf_q;
  logic [WIDX_W-1:0]              idx_q;
  logic                           busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      buf_q  <= pix_i;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && ready_i) begin
      idx_q <= (idx_q == LAST) ? '0 : idx_q + WIDX_W'(1);
      if (idx_q == LAST) busy_q <= 1'b0;
    end
  end

  assign valid_o = busy_q;
  assign word_o  = buf_q[idx_q];
  // buffer can take a new pixel at the coming edge
  assign free_o  = !busy_q || (idx_q == LAST && ready_i);
endmodule

// File: rtl/pix_merge.sv
module pix_merge
  import pm_pkg::*;
#(
  parameter int COORD_W   = 16,
  parameter int SCR_W_DEF = 640,
  parameter int SCR_H_DEF = 480
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_start_i,
  input  logic                 cfg_we_i,
  input  logic [1:0]           cfg_addr_i,
  input  logic [2*COORD_W-1:0] cfg_wdata_i,
  input  logic                 in_en_i,
  input  logic [WORD_W-1:0]    loc_word_i,
  input  logic [WORD_W-1:0]    ups_word_i,
  output logic                 in_rdy_o,
  output logic                 out_valid_o,
  output logic [WORD_W-1:0]    out_data_o,
  input  logic                 out_ready_i
);
  localparam int N_STREAM = 2;
  localparam logic [WIDX_W-1:0] LAST = WIDX_W'(N_WORDS - 1);

  // configuration
  mode_e              mode_q;
  logic [COORD_W-1:0] scr_w_q, scr_h_q, x_lo_q, x_hi_q, y_lo_q, y_hi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= MODE_DEPTH;
      scr_w_q <= COORD_W'(SCR_W_DEF);
      scr_h_q <= COORD_W'(SCR_H_DEF);
      x_lo_q  <= '0;
      x_hi_q  <= '0;
      y_lo_q  <= '0;
      y_hi_q  <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_addr_i)
        2'd0: mode_q <= mode_e'(cfg_wdata_i[1:0]);
        2'd1: {scr_h_q, scr_w_q} <= cfg_wdata_i;
        2'd2: {x_hi_q, x_lo_q}   <= cfg_wdata_i;
        default: {y_hi_q, y_lo_q} <= cfg_wdata_i;
      endcase
    end
  end

  // input word tracking, shared by both streams
  logic [WIDX_W-1:0] widx_q;
  logic              ser_free, take, pix_done;

  assign in_rdy_o = (widx_q != LAST) || ser_free;
  assign take     = in_en_i && in_rdy_o;
  assign pix_done = take && (widx_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   widx_q <= '0;
    else if (take) widx_q <= (widx_q == LAST) ? '0 : widx_q + WIDX_W'(1);
  end

  logic [N_STREAM-1:0][WORD_W-1:0] in_words;
  pix_t                            str_pix [N_STREAM];

  assign in_words[0] = loc_word_i;
  assign in_words[1] = ups_word_i;

  for (genvar s = 0; s < N_STREAM; s++) begin : g_str
    pm_deser u_des (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take),
      .idx_i  (widx_q),
      .word_i (in_words[s]),
      .pix_o  (str_pix[s])
    );
  end

  // scan position
  logic [COORD_W-1:0] scan_x, scan_y;

  pm_scan #(.CW(COORD_W)) u_scan (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (frame_start_i),
    .step_i (pix_done),
    .w_i    (scr_w_q),
    .h_i    (scr_h_q),
    .x_o    (scan_x),
    .y_o    (scan_y)
  );

  pix_t merged;

  pm_merge #(.CW(COORD_W)) u_merge (
    .mode_i (mode_q),
    .loc_i  (str_pix[0]),
    .ups_i  (str_pix[1]),
    .x_i    (scan_x),
    .y_i    (scan_y),
    .x_lo_i (x_lo_q),
    .x_hi_i (x_hi_q),
    .y_lo_i (y_lo_q),
    .y_hi_i (y_hi_q),
    .pix_o  (merged)
  );

  pm_ser u_ser (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (pix_done),
    .pix_i   (merged),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .word_o  (out_data_o),
    .free_o  (ser_free)
  );
endmodule

// File: rtl/pm_chk.sv
module pm_chk #(
  parameter int CW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          frame_start_i,
  input logic          in_en_i,
  input logic          in_rdy_o,
  input logic          out_valid_o,
  input logic          out_ready_i,
  input logic [15:0]   out_data_o,
  input logic          pix_done,
  input logic [CW-1:0] scan_x,
  input logic [CW-1:0] scan_y,
  input logic [CW-1:0] scr_w_q
);
  // words held inside the block: accepted minus emitted
  logic [4:0] occ_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) occ_q <= '0;
    else occ_q <= occ_q + 5'(in_en_i && in_rdy_o) - 5'(out_valid_o && out_ready_i);
  end

  a_r9_hold_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(out_data_o));

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_q <= 5'd7);

  a_r8_frame_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_i |=> scan_x == '0 && scan_y == '0);

  a_r7_x_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_done && !frame_start_i && (scan_x < scr_w_q - CW'(1))
    |=> scan_x == $past(scan_x) + CW'(1) && $stable(scan_y));

  a_r11_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_en_i && !out_valid_o |=> !out_valid_o);
endmodule

bind pix_merge pm_chk #(.CW(COORD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .frame_start_i (frame_start_i),
  .in_en_i       (in_en_i),
  .in_rdy_o      (in_rdy_o),
  .out_valid_o   (out_valid_o),
  .out_ready_i   (out_ready_i),
  .out_data_o    (out_data_o),
  .pix_done      (pix_done),
  .scan_x        (scan_x),
  .scan_y        (scan_y),
  .scr_w_q       (scr_w_q)
);

// File: tb/sim_pix_merge.sv
`timescale 1ns/1ps
module sim_pix_merge;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fs = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        en = 1'b0;
  logic [15:0] lw = '0, uw = '0;
  logic        rdy, ov, ordy = 1'b1;
  logic [15:0] od;

  int checks = 0, fails = 0;
  int cyc = 0;
  bit bp = 0;

  // bench-side configuration model
  int mode_b = 0, bw = 640, bh = 480, bx = 0, by = 0;
  int xlo = 0, xhi = 0, ylo = 0, yhi = 0;

  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  pix_merge u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_start_i(fs),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .in_en_i(en), .loc_word_i(lw), .ups_word_i(uw), .in_rdy_o(rdy),
    .out_valid_o(ov), .out_data_o(od), .out_ready_i(ordy)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] rdiv(input int p);
    return 8'((2 * p + 255) / 510);
  endfunction

  function automatic logic [63:0] mk(input int r, g, b, a, input logic [31:0] z);
    return {z, 8'(a), 8'(b), 8'(g), 8'(r)};
  endfunction

  function automatic logic [63:0] model(input logic [63:0] l, u);
    logic [63:0] o;
    int as, ad;
    as = int'(l[31:24]);
    ad = int'(u[31:24]);
    case (mode_b)
      1: begin
        for (int c = 0; c < 3; c++)
          o[8*c +: 8] = rdiv(as * int'(l[8*c +: 8]) + (255 - as) * int'(u[8*c +: 8]));
        o[31:24] = 8'(as + int'(rdiv(ad * (255 - as))));
        o[63:32] = (l[63:32] < u[63:32]) ? l[63:32] : u[63:32];
      end
      2: o = (bx >= xlo && bx <= xhi && by >= ylo && by <= yhi) ? l : u;
      default: o = (l[63:32] <= u[63:32]) ? l : u;
    endcase
    return o;
  endfunction

  task automatic send_pix(input logic [63:0] l, u, input int gap, input string tag);
    exp_q.push_back(model(l, u));
    tag_q.push_back(tag);
    if (bx >= bw - 1) begin bx = 0; by = (by >= bh - 1) ? 0 : by + 1; end
    else bx++;
    for (int k = 0; k < 4; k++) begin
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        en = 1'b0; lw = 16'hDEAD ^ 16'(cyc); uw = 16'hBEEF ^ 16'(cyc);
      end
      @(negedge clk);
      en = 1'b1; lw = l[16*k +: 16]; uw = u[16*k +: 16];
      #1;
      while (!rdy) begin @(negedge clk); #1; end
    end
    @(negedge clk);
    en = 1'b0; lw = 16'h5A5A; uw = 16'hA5A5;
  endtask

  task automatic cfg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic frame_pulse();
    @(negedge clk); fs = 1'b1;
    @(negedge clk); fs = 1'b0;
    bx = 0; by = 0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    chk(exp_q.size() == 0, "R9 drain", 64'(exp_q.size()), 64'd0);
    repeat (3) @(negedge clk);
  endtask

  // ready pattern, driven on the falling edge
  initial forever begin
    @(negedge clk);
    cyc++;
    ordy <= bp ? (cyc % 3 != 0) : 1'b1;
  end

  // output monitor: samples just before the transferring edge
  initial begin
    logic [63:0] mpix;
    logic [15:0] pd;
    logic [63:0] e;
    string t;
    int mk_i;
    bit stall;
    mk_i = 0; stall = 0; mpix = '0; pd = '0;
    forever begin
      @(negedge clk); #2;
      if (rst_n) begin
        if (stall) chk(ov && od == pd, "R9 stall hold", 64'({ov, od}), 64'({1'b1, pd}));
        if (ov && ordy) begin
          mpix[16*mk_i +: 16] = od;
          if (mk_i == 3) begin
            if (exp_q.size() == 0) chk(1'b0, "R2 unexpected pixel", mpix, 64'd0);
            else begin
              e = exp_q.pop_front();
              t = tag_q.pop_front();
              chk(mpix === e, t, mpix, e);
            end
          end
          mk_i = (mk_i + 1) % 4;
        end
        stall = ov && !ordy;
        pd = od;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] zv[4];
    logic [63:0] l, u;
    int al[7], ad[3];
    zv = '{32'd0, 32'd5, 32'd6, 32'hFFFF_FFFF};
    al = '{0, 1, 77, 128, 200, 254, 255};
    ad = '{0, 100, 255};

    repeat (4) @(negedge clk);
    #2;
    // R1 reset state
    chk(ov == 1'b0, "R1 valid in reset", 64'(ov), 64'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2;
    chk(ov == 1'b0, "R1 valid after reset", 64'(ov), 64'd0);
    chk(rdy == 1'b1, "R1 ready after reset", 64'(rdy), 64'd1);

    // R2 latency and word order, default mode is depth (R1)
    l = mk(8'h11, 8'h22, 8'h33, 8'h44, 32'd3);
    u = mk(8'h55, 8'h66, 8'h77, 8'h88, 32'd9);
    send_pix(l, u, 0, "R1 default depth mode");
    #2;
    chk(ov && od == l[15:0], "R2 first word next cycle", 64'({ov, od}), 64'({1'b1, l[15:0]}));
    drain();

    // R3 depth sweep including ties; R10 mode 3 behaves as depth
    for (int m = 0; m < 2; m++) begin
      cfg(2'd0, m == 0 ? 32'd0 : 32'd3);
      for (int i = 0; i < 4; i++)
        for (int j = 0; j < 4; j++)
          send_pix(mk(i * 16 + j, 200 - i, 7 * j, 9, zv[i]),
                   mk(j * 3, i + 100, 250 - j, 77, zv[j]), 0,
                   m == 0 ? "R3 depth select" : "R10 reserved mode as depth");
      drain();
    end

    // R4 R5 blend sweep over source and destination alpha
    cfg(2'd0, 32'd1); mode_b = 1;
    for (int i = 0; i < 7; i++)
      for (int j = 0; j < 3; j++)
        send_pix(mk(255 - 30 * i, 17 * j, 128, al[i], 32'd100 + 32'(j)),
                 mk(40 * j, 255, 3 * i, ad[j], 32'd101 + 32'(i % 2)), 0,
                 "R4 R5 blend");
    drain();

    // R6 R7 tile over a 4x3 screen, zone x 1..2, y 1..1
    cfg(2'd1, {16'd3, 16'd4}); bw = 4; bh = 3;
    cfg(2'd2, {16'd2, 16'd1}); xlo = 1; xhi = 2;
    cfg(2'd3, {16'd1, 16'd1}); ylo = 1; yhi = 1;
    cfg(2'd0, 32'd2); mode_b = 2;
    frame_pulse();
    for (int n = 0; n < 30; n++)
      send_pix(mk(n, 1, 2, 3, 32'd50), mk(n + 128, 4, 5, 6, 32'd10), 0, "R6 R7 tile wrap");
    drain();
    // R8 frame restart mid-frame
    frame_pulse();
    for (int n = 0; n < 6; n++)
      send_pix(mk(n, 9, 9, 9, 32'd1), mk(n, 8, 8, 8, 32'd2), 0, "R8 frame restart");
    drain();

    // R9 backpressure with R11 enable gaps carrying garbage
    cfg(2'd0, 32'd0); mode_b = 0;
    bp = 1;
    for (int n = 0; n < 12; n++)
      send_pix(mk(n, n + 1, n + 2, n + 3, 32'(n % 3)), mk(n + 9, 0, 1, 2, 32'(n % 4)), n % 3,
               "R9 R11 stall and gaps");
    drain();
    bp = 0;

    // R11 enable low produces nothing
    for (int n = 0; n < 10; n++) begin
      @(negedge clk); en = 1'b0; lw = 16'(n * 97); uw = 16'(n * 31);
      #2;
      chk(ov == 1'b0, "R11 idle no output", 64'(ov), 64'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule